// File: doc/BRIEF.md
# ADC Sample Buffer Writer

This block takes corrected 16-bit conversion results from an analog-to-digital converter and stores them, one per accepted sample, into a halfword buffer in RAM. It writes through a single-cycle memory write port. Software defines the buffer with a start address and a length counted in samples. Software then issues a reset strobe, which parks the channel and rewinds the pointer. A load strobe after that starts the channel. The mode bit is captured at load and selects one of two behaviours. In linear mode the channel stops once the buffer is full. In auto-wrap mode the pointer returns to the start address after the last slot and writing goes on.

Three sticky interrupt flags report progress. The half flag is raised when the lower half of the buffer has been written, taken as floor(length/2) samples. The full flag is raised when the last slot has been written. The overflow flag is raised when a linear channel that has already stopped receives another sample. Each flag is cleared by writing one to its bit of the clear input. The address being written is always visible on a readback port. Dropping the converter enable halts the channel in either mode.

Top module: `adc_sample_dma`

## Requirements
- R1: After `rst` or a `ctl_reset` strobe the channel is idle, no writes happen, and `cur_addr` equals the start address. Samples that arrive before a load are not written.
- R2: A `ctl_load` strobe while idle starts the channel. `ctl_wrap` is sampled at that load: 0 selects linear mode and 1 selects auto-wrap. Later changes to `ctl_wrap` have no effect until the next load.
- R3: A sample offered while running (`smp_valid` and `adc_enable` both high) drives `mem_we` high in the same cycle. It carries `mem_addr` = `cur_addr` and `mem_wdata` = `smp_data`, and the pointer then advances by 2 bytes.
- R4: In linear mode the channel writes exactly `buf_len` samples, then stops and sets `flag_full`. Further samples are not written.
- R5: A sample offered to a stopped linear channel while `adc_enable` is high sets `flag_ovf`.
- R6: In auto-wrap mode, writing the last slot sets `flag_full` and returns `cur_addr` to the start address, and writing continues from there.
- R7: `flag_half` is set when the write that completes sample number floor(`buf_len`/2) of a pass is made. It is never set when `buf_len` is 1.
- R8: The flags stay set until cleared through `flag_clr`, where bit 0 clears half, bit 1 clears full and bit 2 clears overflow. A flag being set in the same cycle wins over its clear.
- R9: `adc_enable` low makes the channel idle in either mode. Nothing is written after that until a new load.
- R10: `cur_addr` always equals the start address with bit 0 forced to 0, plus twice the number of samples written in the current pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_reset | input | 1 | Channel reset strobe: idles the channel and rewinds the pointer |
| ctl_load | input | 1 | Start strobe, honoured while idle |
| ctl_wrap | input | 1 | Mode select captured at load: 0 linear, 1 auto-wrap |
| adc_enable | input | 1 | Converter enable; low halts the channel |
| buf_base | input | ADDR_W | Buffer start byte address (bit 0 ignored) |
| buf_len | input | SIZE_W | Buffer length in 16-bit samples |
| smp_valid | input | 1 | A corrected conversion result is offered this cycle |
| smp_data | input | DATA_W | Corrected conversion result |
| flag_clr | input | 3 | Write-one-to-clear: bit 0 half, bit 1 full, bit 2 overflow |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | ADDR_W | RAM byte address of the write |
| mem_wdata | output | DATA_W | RAM write data |
| cur_addr | output | ADDR_W | Address the next sample will be written to |
| flag_half | output | 1 | Lower half filled (sticky) |
| flag_full | output | 1 | Last slot written (sticky) |
| flag_ovf | output | 1 | Sample arrived after a linear stop (sticky) |

## Verification
A table of runs varies the mode, the buffer length and the number of samples offered. Runs that stop short of the end, end exactly at the end, and overrun it separate the linear stop and overflow behaviour from normal filling. Auto-wrap runs longer than the buffer show that later samples overwrite the first slots. Odd lengths and a length of one pin down the half-point rule. Directed sequences then cover the case where the mode changes after load, a disable in the middle of a run, a channel reset in the middle of a run, an odd start address and selective flag clearing.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;

    // Channel operating state
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_STOP = 2'd2
    } ch_state_e;

    // Interrupt flag vector; bit 0 half, bit 1 full, bit 2 overflow
    typedef struct packed {
        logic ovf;
        logic full;
        logic half;
    } dma_flags_t;

    // Per-cycle events reported by the index counter
    typedef struct packed {
        logic wrote;
        logic hit_half;
        logic hit_end;
    } ptr_evt_t;

    localparam int FLAG_W = $bits(dma_flags_t);

endpackage

// File: rtl/dma_index_ctr.sv
module dma_index_ctr
    import adc_dma_pkg::*;
#(
    parameter int SIZE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    input  logic              wrap_mode,
    input  logic [SIZE_W-1:0] len,
    output logic [SIZE_W-1:0] idx,
    output ptr_evt_t          evt
);

    logic [SIZE_W-1:0] nxt;
    logic [SIZE_W-1:0] half_pt;

    assign nxt     = idx + SIZE_W'(1);
    assign half_pt = len >> 1;

    always_comb begin
        evt.wrote    = step;
        evt.hit_end  = step && (nxt == len);
        evt.hit_half = step && (half_pt != '0) && (nxt == half_pt);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (step) begin
            idx <= (evt.hit_end && wrap_mode) ? '0 : nxt;
        end
    end

endmodule

// File: rtl/dma_flag_reg.sv
module dma_flag_reg
    import adc_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dma_flags_t set,
    input  dma_flags_t clr,
    output dma_flags_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= dma_flags_t'((q & ~clr) | set);
        end
    end

endmodule

// File: rtl/adc_sample_dma.sv
module adc_sample_dma
    import adc_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_reset,
    input  logic              ctl_load,
    input  logic              ctl_wrap,
    input  logic              adc_enable,
    input  logic [ADDR_W-1:0] buf_base,
    input  logic [SIZE_W-1:0] buf_len,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [FLAG_W-1:0] flag_clr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              flag_half,
    output logic              flag_full,
    output logic              flag_ovf
);

    localparam int OFS_W = SIZE_W + 1;

    ch_state_e         state_q, state_d;
    logic              wrap_q;
    logic              accept;
    logic              step;
    logic [SIZE_W-1:0] idx;
    ptr_evt_t          evt;
    dma_flags_t        fl_set, fl_q;
    logic [ADDR_W-1:0] base_even;

    assign accept = smp_valid && adc_enable;
    assign step   = (state_q == CH_RUN) && accept;

    dma_index_ctr #(.SIZE_W(SIZE_W)) u_idx (
        .clk       (clk),
        .rst       (rst),
        .clr       (ctl_reset),
        .step      (step),
        .wrap_mode (wrap_q),
        .len       (buf_len),
        .idx       (idx),
        .evt       (evt)
    );

    // Channel state machine
    always_comb begin
        state_d = state_q;
        if (ctl_reset || !adc_enable) begin
            state_d = CH_IDLE;
        end else begin
            case (state_q)
                CH_IDLE: if (ctl_load) state_d = CH_RUN;
                CH_RUN:  if (evt.hit_end && !wrap_q) state_d = CH_STOP;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            wrap_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == CH_IDLE && state_d == CH_RUN) begin
                wrap_q <= ctl_wrap;
            end
        end
    end

    // Flag events
    always_comb begin
        fl_set.half = evt.hit_half;
        fl_set.full = evt.hit_end;
        fl_set.ovf  = (state_q == CH_STOP) && accept && !ctl_reset;
    end

    dma_flag_reg u_flags (
        .clk (clk),
        .rst (rst),
        .set (fl_set),
        .clr (dma_flags_t'(flag_clr)),
        .q   (fl_q)
    );

    // Address generation: halfword-aligned base plus 2 bytes per sample
    assign base_even = {buf_base[ADDR_W-1:1], 1'b0};
    assign cur_addr  = base_even + ADDR_W'(OFS_W'({idx, 1'b0}));

    assign mem_we    = evt.wrote;
    assign mem_addr  = cur_addr;
    assign mem_wdata = smp_data;

    assign flag_half = fl_q.half;
    assign flag_full = fl_q.full;
    assign flag_ovf  = fl_q.ovf;

endmodule

// File: rtl/adc_dma_chk.sv
module adc_dma_chk
    import adc_dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_reset,
    input logic              smp_valid,
    input logic              adc_enable,
    input logic [ADDR_W-1:0] buf_base,
    input logic [2:0]        flag_clr,
    input logic              mem_we,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              flag_half,
    input logic              flag_full,
    input logic              flag_ovf,
    input ch_state_e         state
);

    // R3
    we_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (smp_valid && adc_enable));

    // R1
    rewind_on_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_reset |=> (cur_addr == {$past(buf_base[ADDR_W-1:1]), 1'b0}) && !mem_we);

    // R4
    no_write_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (state == CH_STOP) |-> !mem_we);

    // R5
    ovf_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_ovf) |-> $past(smp_valid && adc_enable));

    // R7
    half_has_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_half) |-> $past(mem_we));

    // R8
    half_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_half && !flag_clr[0]) |=> flag_half);

    // R8
    full_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_full && !flag_clr[1]) |=> flag_full);

    // R9
    halt_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
        !adc_enable |=> (state == CH_IDLE));

    // R10
    addr_even_chk: assert property (@(posedge clk) disable iff (rst)
        cur_addr[0] == 1'b0);

endmodule

bind adc_sample_dma adc_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_reset  (ctl_reset),
    .smp_valid  (smp_valid),
    .adc_enable (adc_enable),
    .buf_base   (buf_base),
    .flag_clr   (flag_clr),
    .mem_we     (mem_we),
    .cur_addr   (cur_addr),
    .flag_half  (flag_half),
    .flag_full  (flag_full),
    .flag_ovf   (flag_ovf),
    .state      (state_q)
);

// File: tb/adc_sample_dma_bench.sv
module adc_sample_dma_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int SIZE_W = 10;
    localparam int DATA_W = 16;
    localparam logic [ADDR_W-1:0] BASE = 16'h0040;
    localparam int WATCHDOG = 20000;

    typedef struct packed {
        logic       wrap;
        logic [7:0] len;
        logic [7:0] n;
        logic       e_half;
        logic       e_full;
        logic       e_ovf;
        logic [7:0] e_idx;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'd8, 8'd8,  1'b1, 1'b1, 1'b0, 8'd8},
        '{1'b0, 8'd8, 8'd10, 1'b1, 1'b1, 1'b1, 8'd8},
        '{1'b0, 8'd8, 8'd3,  1'b0, 1'b0, 1'b0, 8'd3},
        '{1'b0, 8'd5, 8'd2,  1'b1, 1'b0, 1'b0, 8'd2},
        '{1'b1, 8'd4, 8'd6,  1'b1, 1'b1, 1'b0, 8'd2},
        '{1'b1, 8'd1, 8'd3,  1'b0, 1'b1, 1'b0, 8'd0},
        '{1'b0, 8'd1, 8'd1,  1'b0, 1'b1, 1'b0, 8'd1}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctl_reset = 1'b0;
    logic              ctl_load = 1'b0;
    logic              ctl_wrap = 1'b0;
    logic              adc_enable = 1'b1;
    logic [ADDR_W-1:0] buf_base = BASE;
    logic [SIZE_W-1:0] buf_len = '0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic [2:0]        flag_clr = '0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [ADDR_W-1:0] cur_addr;
    logic              flag_half, flag_full, flag_ovf;

    logic [DATA_W-1:0] ram [256];
    logic [DATA_W-1:0] exp_ram [256];
    logic              ram_clr = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_sample_dma #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_adc_sample_dma (
        .clk(clk), .rst(rst), .ctl_reset(ctl_reset), .ctl_load(ctl_load),
        .ctl_wrap(ctl_wrap), .adc_enable(adc_enable), .buf_base(buf_base),
        .buf_len(buf_len), .smp_valid(smp_valid), .smp_data(smp_data),
        .flag_clr(flag_clr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cur_addr(cur_addr), .flag_half(flag_half),
        .flag_full(flag_full), .flag_ovf(flag_ovf)
    );

    // RAM model
    always @(posedge clk) begin
        if (ram_clr) begin
            for (int i = 0; i < 256; i++) ram[i] <= '0;
        end else if (mem_we) begin
            ram[mem_addr[8:1]] <= mem_wdata;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One-cycle strobes, driven from a negedge
    task automatic chan_reset();
        ctl_reset = 1'b1; flag_clr = 3'b111; ram_clr = 1'b1;
        @(negedge clk);
        ctl_reset = 1'b0; flag_clr = 3'b000; ram_clr = 1'b0;
    endtask

    task automatic chan_load(input logic wrap);
        ctl_wrap = wrap; ctl_load = 1'b1;
        @(negedge clk);
        ctl_load = 1'b0;
    endtask

    task automatic send(input logic [15:0] d);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic run_vector(input int v);
        vec_t t;
        int mism;
        t = VECS[v];
        for (int i = 0; i < 256; i++) exp_ram[i] = '0;
        buf_len = SIZE_W'(t.len);
        chan_reset();
        chan_load(t.wrap);
        for (int k = 0; k < int'(t.n); k++) begin
            logic [15:0] d;
            d = 16'hA000 + 16'(v * 256) + 16'(k);
            if (t.wrap) exp_ram[32 + (k % int'(t.len))] = d;
            else if (k < int'(t.len)) exp_ram[32 + k] = d;
            send(d);
        end
        @(negedge clk);
        mism = 0;
        for (int i = 0; i < 256; i++) if (ram[i] !== exp_ram[i]) mism++;
        chk($sformatf("R3/R4/R6 vec%0d ram mismatches", v), 32'(mism), 32'd0);
        chk($sformatf("R7 vec%0d half", v), 32'(flag_half), 32'(t.e_half));
        chk($sformatf("R4/R6 vec%0d full", v), 32'(flag_full), 32'(t.e_full));
        chk($sformatf("R5 vec%0d ovf", v), 32'(flag_ovf), 32'(t.e_ovf));
        chk($sformatf("R10 vec%0d cur_addr", v), 32'(cur_addr), 32'(BASE + 16'(2 * int'(t.e_idx))));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 reset flags", {29'd0, flag_ovf, flag_full, flag_half}, 32'd0);
        chk("R1 reset cur_addr", 32'(cur_addr), 32'(BASE));
        // R1: sample before load ignored
        smp_valid = 1'b1; smp_data = 16'h1234;
        #1;
        chk("R1 no write before load", 32'(mem_we), 32'd0);
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R1 cur_addr unchanged", 32'(cur_addr), 32'(BASE));

        for (int v = 0; v < NVEC; v++) run_vector(v);

        // R3: same-cycle write strobe, address and data
        buf_len = 10'd4;
        chan_reset();
        chan_load(1'b0);
        smp_valid = 1'b1; smp_data = 16'h5A5A;
        #1;
        chk("R3 mem_we", 32'(mem_we), 32'd1);
        chk("R3 mem_addr", 32'(mem_addr), 32'(BASE));
        chk("R3 mem_wdata", 32'(mem_wdata), 32'h5A5A);
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R3 advance by 2", 32'(cur_addr), 32'(BASE + 16'd2));

        // R8: selective clear, set-wins
        buf_len = 10'd2;
        chan_reset();
        chan_load(1'b0);
        send(16'h0001);
        send(16'h0002);
        flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = 3'b000;
        chk("R8 half cleared", 32'(flag_half), 32'd0);
        chk("R8 full kept", 32'(flag_full), 32'd1);
        // overflow set while its clear bit is high: set wins
        flag_clr = 3'b100; smp_valid = 1'b1;
        @(negedge clk);
        flag_clr = 3'b000; smp_valid = 1'b0;
        chk("R8 set wins over clear", 32'(flag_ovf), 32'd1);
        flag_clr = 3'b100;
        @(negedge clk);
        flag_clr = 3'b000;
        chk("R8 ovf cleared", 32'(flag_ovf), 32'd0);

        // R2: mode latched at load
        buf_len = 10'd2;
        chan_reset();
        chan_load(1'b1);
        ctl_wrap = 1'b0;
        send(16'h0011);
        send(16'h0012);
        send(16'h0013);
        chk("R2 wrap kept after mode change", 32'(cur_addr), 32'(BASE + 16'd2));
        chk("R2 no overflow in wrap", 32'(flag_ovf), 32'd0);

        // R9: disable halts the channel
        buf_len = 10'd8;
        chan_reset();
        chan_load(1'b0);
        send(16'h0021);
        send(16'h0022);
        adc_enable = 1'b0;
        @(negedge clk);
        adc_enable = 1'b1;
        smp_valid = 1'b1; smp_data = 16'h0023;
        #1;
        chk("R9 no write after disable", 32'(mem_we), 32'd0);
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R9 pointer held", 32'(cur_addr), 32'(BASE + 16'd4));

        // R1: channel reset mid-run
        buf_len = 10'd8;
        chan_reset();
        chan_load(1'b0);
        send(16'h0031);
        send(16'h0032);
        send(16'h0033);
        chan_reset();
        chk("R1 rewind mid-run", 32'(cur_addr), 32'(BASE));
        smp_valid = 1'b1;
        #1;
        chk("R1 idle after reset", 32'(mem_we), 32'd0);
        @(negedge clk);
        smp_valid = 1'b0;

        // R10: odd start address ignores bit 0
        buf_base = 16'h0041;
        #1;
        chk("R10 odd base", 32'(cur_addr), 32'h0040);
        buf_base = BASE;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule